// File: doc/BRIEF.md
# Lock and commit configuration guard

This block write-protects configuration registers that sit elsewhere in an error-handling unit. Every protected resource has a lock bit and a commit bit. While its commit bit is clear, software may set and clear the lock bit as often as it likes. Once the commit bit is set, both bits hold their values until the next reset. A resource whose lock and commit bits are both set refuses every further write to its registers.

There are three banks of lock/commit pairs. The group bank has one pair per error group and guards that group's enable-set, enable-clear and priority registers. The critical bank has one pair per group and guards the critical-influence mask registers. The global bank guards a handful of single items, and only some of its bit positions exist. The block takes configuration writes to its own six lock/commit registers and reads them back. For write requests aimed at protected registers, it returns a grant. It also drives a permit vector to each protected register file and keeps a sticky flag that records any refused write.

Top module: `lock_commit_guard`

## Requirements
- R1: After reset, every lock and commit bit is 0, every permit bit is 1 and `violation` is 0. A later reset clears a committed configuration in the same way.
- R2: While a commit bit is 0, a write to its lock register loads the written value into that lock bit. The value shows on readback after the write edge.
- R3: A commit bit is set by writing 1 to it. Once it is 1, a write of 0 leaves it at 1.
- R4: While a commit bit is 1, writes to the corresponding lock bit have no effect.
- R5: Permit bit N of a bank is 0 exactly when lock bit N and commit bit N of that bank are both 1. Bit N of every register and vector belongs to resource N.
- R6: Setting a commit bit while its lock bit is 0 freezes that lock at 0, so the resource stays writable even after lock register writes of all ones.
- R7: `prot_grant` is combinationally `prot_wr_en` AND the permit bit of the addressed resource. The domain encoding is: 0 = group bank, 1 = critical bank, 2 = global bank.
- R8: A protected write request whose addressed permit bit is 0 sets `violation` on the next clock edge. The flag then stays 1 until reset, and granted writes never set it.
- R9: In the global bank only bits 0 (watchdog config), 1 (pin monitor), 2 (error pin), 5 (soft reset) and 8 (global enable) exist. All other bits read 0, ignore writes and always permit.
- R10: Readback selector encoding for `rd_sel` and `cfg_wr_sel`: 0 = group lock, 1 = group commit, 2 = critical lock, 3 = critical commit, 4 = global lock, 5 = global commit. Selectors 6 and 7 read 0 and write nothing.
- R11: The group and critical banks are independent. Writes to one never change the other's bits or permits.
- R12: Domain 3, or an index at or beyond the addressed bank's width, is never granted and never sets `violation`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for a lock/commit register |
| cfg_wr_sel | input | 3 | Register selector for the write (R10 encoding) |
| cfg_wr_data | input | 32 | Write data, bit N for resource N |
| rd_sel | input | 3 | Readback selector (R10 encoding) |
| rd_data | output | 32 | Readback of the selected register, zero-extended |
| prot_wr_en | input | 1 | A write to a protected register is requested |
| prot_domain | input | 2 | Bank of the addressed resource |
| prot_index | input | 5 | Resource index within the bank |
| prot_grant | output | 1 | The requested protected write may proceed |
| grp_permit | output | 32 | Per-group write permit for enable and priority registers |
| crit_permit | output | 32 | Per-group write permit for critical-influence masks |
| glb_permit | output | 9 | Per-item write permit for global configuration |
| violation | output | 1 | Sticky flag: a protected write was refused |

## Verification
The lock register is written with a pattern, then cleared, then rewritten. This separates free writability before commit (R2) from a lock that never loads. Commit is then applied to two kinds of bits. On a bit whose lock is 1 it must block. On a bit whose lock is 0 it must freeze the bit open, and a later all-ones lock write shows the difference between the two cases. Protected write requests are sent to unlocked, locked-uncommitted, committed, reserved-domain and out-of-range targets. This tells grants apart from refusals and shows which refusals are allowed to raise the sticky flag. A reference model recomputes every output on every cycle.

// File: rtl/lcg_pkg.sv
package lcg_pkg;

  // Register selector for configuration writes and readback
  typedef enum logic [2:0] {
    SEL_GRP_LOCK    = 3'd0,
    SEL_GRP_COMMIT  = 3'd1,
    SEL_CRIT_LOCK   = 3'd2,
    SEL_CRIT_COMMIT = 3'd3,
    SEL_GLB_LOCK    = 3'd4,
    SEL_GLB_COMMIT  = 3'd5
  } cfg_sel_e;

  // Bank addressed by a protected write request
  typedef enum logic [1:0] {
    DOM_GROUP  = 2'd0,
    DOM_CRIT   = 2'd1,
    DOM_GLOBAL = 2'd2,
    DOM_NONE   = 2'd3
  } prot_dom_e;

  // Next lock value: frozen once committed, otherwise follows a write
  function automatic logic lock_next(logic lk, logic cm, logic we, logic d);
    if (cm)      return lk;
    else if (we) return d;
    else         return lk;
  endfunction

  // Next commit value: sets on a written one, never clears
  function automatic logic commit_next(logic cm, logic we, logic d);
    return cm | (we & d);
  endfunction

  // A resource is writable unless it is both locked and committed
  function automatic logic permit_of(logic lk, logic cm);
    return !(lk && cm);
  endfunction

endpackage

// File: rtl/lcg_pair_bank.sv
module lcg_pair_bank
  import lcg_pkg::*;
#(
  parameter int W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lock_we,
  input  logic         commit_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lock_q,
  output logic [W-1:0] commit_q,
  output logic [W-1:0] permit
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_live
      logic lk_r, cm_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lk_r <= 1'b0;
          cm_r <= 1'b0;
        end else begin
          lk_r <= lock_next(lk_r, cm_r, lock_we, wdata[i]);
          cm_r <= commit_next(cm_r, commit_we, wdata[i]);
        end
      end
      assign lock_q[i]   = lk_r;
      assign commit_q[i] = cm_r;
    end else begin : g_tie
      logic unused_bit;
      assign unused_bit  = wdata[i];
      assign lock_q[i]   = 1'b0;
      assign commit_q[i] = 1'b0;
    end
    assign permit[i] = permit_of(lock_q[i], commit_q[i]);
  end

endmodule

// File: rtl/lcg_access_arb.sv
module lcg_access_arb
  import lcg_pkg::*;
#(
  parameter int NUM_GROUPS = 32,
  parameter int GLB_W      = 9,
  parameter int IDX_W      = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prot_wr_en,
  input  logic [1:0]            prot_domain,
  input  logic [IDX_W-1:0]      prot_index,
  input  logic [NUM_GROUPS-1:0] grp_permit,
  input  logic [NUM_GROUPS-1:0] crit_permit,
  input  logic [GLB_W-1:0]      glb_permit,
  output logic                  grant,
  output logic                  blocked_hit,
  output logic                  violation
);

  logic in_range;
  logic sel_permit;

  always_comb begin
    in_range   = 1'b0;
    sel_permit = 1'b0;
    unique case (prot_dom_e'(prot_domain))
      DOM_GROUP: begin
        for (int i = 0; i < NUM_GROUPS; i++)
          if (prot_index == IDX_W'(i)) begin
            in_range   = 1'b1;
            sel_permit = grp_permit[i];
          end
      end
      DOM_CRIT: begin
        for (int i = 0; i < NUM_GROUPS; i++)
          if (prot_index == IDX_W'(i)) begin
            in_range   = 1'b1;
            sel_permit = crit_permit[i];
          end
      end
      DOM_GLOBAL: begin
        for (int i = 0; i < GLB_W; i++)
          if (prot_index == IDX_W'(i)) begin
            in_range   = 1'b1;
            sel_permit = glb_permit[i];
          end
      end
      default: begin
        in_range   = 1'b0;
        sel_permit = 1'b0;
      end
    endcase
  end

  assign grant       = prot_wr_en && in_range && sel_permit;
  assign blocked_hit = prot_wr_en && in_range && !sel_permit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           violation <= 1'b0;
    else if (blocked_hit) violation <= 1'b1;
  end

endmodule

// File: rtl/lock_commit_guard.sv
module lock_commit_guard
  import lcg_pkg::*;
#(
  parameter int NUM_GROUPS = 32,
  parameter int GLB_W      = 9,
  parameter logic [GLB_W-1:0] GLB_IMPL = 9'h127,
  parameter int DATA_W     = 32,
  localparam int IDX_W     = $clog2(NUM_GROUPS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr_en,
  input  logic [2:0]            cfg_wr_sel,
  input  logic [DATA_W-1:0]     cfg_wr_data,
  input  logic [2:0]            rd_sel,
  output logic [DATA_W-1:0]     rd_data,
  input  logic                  prot_wr_en,
  input  logic [1:0]            prot_domain,
  input  logic [IDX_W-1:0]      prot_index,
  output logic                  prot_grant,
  output logic [NUM_GROUPS-1:0] grp_permit,
  output logic [NUM_GROUPS-1:0] crit_permit,
  output logic [GLB_W-1:0]      glb_permit,
  output logic                  violation
);

  // Decoded write strobes, one per configuration register
  logic we_grp_lock, we_grp_commit, we_crit_lock, we_crit_commit;
  logic we_glb_lock, we_glb_commit;

  assign we_grp_lock    = cfg_wr_en && (cfg_sel_e'(cfg_wr_sel) == SEL_GRP_LOCK);
  assign we_grp_commit  = cfg_wr_en && (cfg_sel_e'(cfg_wr_sel) == SEL_GRP_COMMIT);
  assign we_crit_lock   = cfg_wr_en && (cfg_sel_e'(cfg_wr_sel) == SEL_CRIT_LOCK);
  assign we_crit_commit = cfg_wr_en && (cfg_sel_e'(cfg_wr_sel) == SEL_CRIT_COMMIT);
  assign we_glb_lock    = cfg_wr_en && (cfg_sel_e'(cfg_wr_sel) == SEL_GLB_LOCK);
  assign we_glb_commit  = cfg_wr_en && (cfg_sel_e'(cfg_wr_sel) == SEL_GLB_COMMIT);

  logic [NUM_GROUPS-1:0] grp_lock, grp_commit, crit_lock, crit_commit;
  logic [GLB_W-1:0]      glb_lock, glb_commit;
  logic                  blocked_hit;

  lcg_pair_bank #(.W(NUM_GROUPS), .IMPL('1)) u_grp (
    .clk(clk), .rst_n(rst_n),
    .lock_we(we_grp_lock), .commit_we(we_grp_commit),
    .wdata(cfg_wr_data[NUM_GROUPS-1:0]),
    .lock_q(grp_lock), .commit_q(grp_commit), .permit(grp_permit)
  );

  lcg_pair_bank #(.W(NUM_GROUPS), .IMPL('1)) u_crit (
    .clk(clk), .rst_n(rst_n),
    .lock_we(we_crit_lock), .commit_we(we_crit_commit),
    .wdata(cfg_wr_data[NUM_GROUPS-1:0]),
    .lock_q(crit_lock), .commit_q(crit_commit), .permit(crit_permit)
  );

  lcg_pair_bank #(.W(GLB_W), .IMPL(GLB_IMPL)) u_glb (
    .clk(clk), .rst_n(rst_n),
    .lock_we(we_glb_lock), .commit_we(we_glb_commit),
    .wdata(cfg_wr_data[GLB_W-1:0]),
    .lock_q(glb_lock), .commit_q(glb_commit), .permit(glb_permit)
  );

  lcg_access_arb #(.NUM_GROUPS(NUM_GROUPS), .GLB_W(GLB_W), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .prot_wr_en(prot_wr_en), .prot_domain(prot_domain), .prot_index(prot_index),
    .grp_permit(grp_permit), .crit_permit(crit_permit), .glb_permit(glb_permit),
    .grant(prot_grant), .blocked_hit(blocked_hit), .violation(violation)
  );

  // Readback mux, zero-extended to the bus width
  always_comb begin
    case (cfg_sel_e'(rd_sel))
      SEL_GRP_LOCK:    rd_data = DATA_W'(grp_lock);
      SEL_GRP_COMMIT:  rd_data = DATA_W'(grp_commit);
      SEL_CRIT_LOCK:   rd_data = DATA_W'(crit_lock);
      SEL_CRIT_COMMIT: rd_data = DATA_W'(crit_commit);
      SEL_GLB_LOCK:    rd_data = DATA_W'(glb_lock);
      SEL_GLB_COMMIT:  rd_data = DATA_W'(glb_commit);
      default:         rd_data = '0;
    endcase
  end

endmodule

// File: rtl/lcg_checker.sv
module lcg_checker #(
  parameter int NUM_GROUPS = 32,
  parameter int GLB_W      = 9,
  parameter int IDX_W      = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_wr_en,
  input logic [NUM_GROUPS-1:0] grp_lock,
  input logic [NUM_GROUPS-1:0] grp_commit,
  input logic [NUM_GROUPS-1:0] crit_commit,
  input logic [GLB_W-1:0]      glb_lock,
  input logic [GLB_W-1:0]      glb_commit,
  input logic [NUM_GROUPS-1:0] grp_permit,
  input logic                  prot_wr_en,
  input logic [1:0]            prot_domain,
  input logic [IDX_W-1:0]      prot_index,
  input logic                  prot_grant,
  input logic                  blocked_hit,
  input logic                  violation
);

  // R3: commit bits never fall while out of reset
  p_commit_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(grp_commit) & ~grp_commit) == '0) &&
    (($past(crit_commit) & ~crit_commit) == '0) &&
    (($past(glb_commit) & ~glb_commit) == '0));

  // R4: a lock bit whose commit was set stays unchanged
  p_lock_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (((grp_lock ^ $past(grp_lock)) & $past(grp_commit)) == '0) &&
    (((glb_lock ^ $past(glb_lock)) & $past(glb_commit)) == '0));

  // R5: a permit bit can only drop after a configuration write
  p_permit_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~grp_permit & $past(grp_permit)) != '0) |-> $past(cfg_wr_en));

  // R7: a grant in the group bank needs that group's permit
  p_grant_permit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_grant && prot_domain == 2'd0) |-> grp_permit[prot_index]);

  // R7: no grant without a request
  p_grant_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prot_grant |-> prot_wr_en);

  // R8: violation is sticky
  p_violation_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation);

  // R8: violation only rises after a refused request
  p_violation_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(violation) |-> ($past(blocked_hit) && $past(prot_wr_en) && !$past(prot_grant)));

endmodule

bind lock_commit_guard lcg_checker #(
  .NUM_GROUPS(NUM_GROUPS), .GLB_W(GLB_W), .IDX_W(IDX_W)
) u_lcg_checker (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en),
  .grp_lock(grp_lock), .grp_commit(grp_commit), .crit_commit(crit_commit),
  .glb_lock(glb_lock), .glb_commit(glb_commit), .grp_permit(grp_permit),
  .prot_wr_en(prot_wr_en), .prot_domain(prot_domain), .prot_index(prot_index),
  .prot_grant(prot_grant), .blocked_hit(blocked_hit), .violation(violation)
);

// File: tb/tb_lock_commit_guard.sv
`timescale 1ns/1ps
module tb_lock_commit_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [2:0]  cfg_wr_sel = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        prot_wr_en = 1'b0;
  logic [1:0]  prot_domain = '0;
  logic [4:0]  prot_index = '0;
  logic        prot_grant;
  logic [31:0] grp_permit, crit_permit;
  logic [8:0]  glb_permit;
  logic        violation;

  lock_commit_guard dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .prot_wr_en(prot_wr_en), .prot_domain(prot_domain), .prot_index(prot_index),
    .prot_grant(prot_grant), .grp_permit(grp_permit), .crit_permit(crit_permit),
    .glb_permit(glb_permit), .violation(violation)
  );

  always #4 clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  string tag      = "R1";
  bit    done     = 0;

  // Reference state: one bit per resource, held in int-indexed arrays
  bit m_lk [3][32];
  bit m_cm [3][32];
  bit m_viol;

  function automatic bit exists(int bank, int b);
    if (bank < 2) return b < 32;
    return b inside {0, 1, 2, 5, 8};
  endfunction

  function automatic bit open_res(int bank, int b);
    if (!exists(bank, b)) return 1'b1;
    return !(m_lk[bank][b] == 1 && m_cm[bank][b] == 1);
  endfunction

  function automatic int bank_w(int bank);
    return (bank < 2) ? 32 : 9;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 3; k++)
      for (int b = 0; b < 32; b++) begin
        m_lk[k][b] = 0;
        m_cm[k][b] = 0;
      end
    m_viol = 0;
  endtask

  function automatic logic [31:0] exp_rd(int sel);
    logic [31:0] v = '0;
    if (sel > 5) return '0;
    for (int b = 0; b < bank_w(sel / 2); b++)
      if (exists(sel / 2, b))
        v[b] = (sel % 2 == 0) ? m_lk[sel / 2][b] : m_cm[sel / 2][b];
    return v;
  endfunction

  function automatic logic [31:0] exp_perm(int bank);
    logic [31:0] v = '0;
    for (int b = 0; b < bank_w(bank); b++) v[b] = open_res(bank, b);
    return v;
  endfunction

  function automatic bit req_in_range();
    return (prot_domain != 2'd3) && (int'(prot_index) < bank_w(int'(prot_domain)));
  endfunction

  function automatic bit exp_grant();
    if (!prot_wr_en || !req_in_range()) return 1'b0;
    return open_res(int'(prot_domain), int'(prot_index));
  endfunction

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("rd_data", rd_data, exp_rd(int'(rd_sel)));
    check("grp_permit", grp_permit, exp_perm(0));
    check("crit_permit", crit_permit, exp_perm(1));
    check("glb_permit", {23'd0, glb_permit}, exp_perm(2));
    check("prot_grant", {31'd0, prot_grant}, {31'd0, exp_grant()});
    check("violation", {31'd0, violation}, {31'd0, m_viol});
  endtask

  // Model update for one clock edge, using the inputs of that cycle
  task automatic model_edge();
    int sel  = int'(cfg_wr_sel);
    int bank = sel / 2;
    if (prot_wr_en && req_in_range() && !open_res(int'(prot_domain), int'(prot_index)))
      m_viol = 1;
    if (cfg_wr_en && sel <= 5) begin
      for (int b = 0; b < bank_w(bank); b++) begin
        if (!exists(bank, b)) continue;
        if (sel % 2 == 0) begin
          if (!m_cm[bank][b]) m_lk[bank][b] = cfg_wr_data[b];
        end else begin
          if (cfg_wr_data[b]) m_cm[bank][b] = 1;
        end
      end
    end
  endtask

  // One cycle: drive at the falling edge, compare, then advance the model
  task automatic step(bit we, int sel, logic [31:0] d, bit pe, int dom, int idx, int rs);
    @(negedge clk);
    cfg_wr_en   = we;
    cfg_wr_sel  = 3'(sel);
    cfg_wr_data = d;
    prot_wr_en  = pe;
    prot_domain = 2'(dom);
    prot_index  = 5'(idx);
    rd_sel      = 3'(rs);
    #1;
    compare_all();
    @(posedge clk);
    model_edge();
  endtask

  task automatic cfg(int sel, logic [31:0] d, int rs);
    step(1, sel, d, 0, 0, 0, rs);
  endtask

  task automatic prot(int dom, int idx, int rs);
    step(0, 0, '0, 1, dom, idx, rs);
  endtask

  task automatic idle(int rs);
    step(0, 0, '0, 0, 0, 0, rs);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    cfg_wr_en = 0;
    prot_wr_en = 0;
    model_reset();
    @(negedge clk);
    #1;
    compare_all();
    rst_n = 1;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
      $finish;
    end
  end

  initial begin
    model_reset();
    tag = "R1";
    do_reset();
    for (int s = 0; s < 6; s++) idle(s);

    tag = "R2";
    cfg(0, 32'h0000_0031, 0);
    idle(0);
    cfg(0, 32'h0000_0000, 0);
    idle(0);
    cfg(0, 32'h0000_0030, 0);
    idle(0);

    tag = "R7";
    prot(0, 4, 0);
    prot(1, 3, 2);
    prot(2, 8, 4);

    tag = "R12";
    prot(3, 0, 0);
    prot(2, 20, 4);
    idle(0);

    tag = "R5";
    cfg(1, 32'h0000_0010, 1);
    idle(1);
    tag = "R3";
    cfg(1, 32'h0000_0000, 1);
    idle(1);

    tag = "R4";
    cfg(0, 32'h0000_0000, 0);
    idle(0);

    tag = "R6";
    cfg(1, 32'h0000_0400, 1);
    cfg(0, 32'hFFFF_FFFF, 0);
    idle(0);
    prot(0, 10, 1);

    tag = "R8";
    prot(0, 4, 0);
    idle(0);
    prot(0, 5, 0);
    idle(0);

    tag = "R11";
    cfg(2, 32'h0000_0010, 2);
    cfg(3, 32'h0000_0010, 3);
    idle(0);
    prot(1, 4, 2);
    prot(0, 5, 3);

    tag = "R9";
    cfg(4, 32'hFFFF_FFFF, 4);
    idle(4);
    cfg(5, 32'hFFFF_FFFF, 5);
    idle(5);
    prot(2, 3, 4);
    prot(2, 8, 5);

    tag = "R10";
    for (int s = 0; s < 8; s++) idle(s);
    cfg(6, 32'hFFFF_FFFF, 6);
    cfg(7, 32'hFFFF_FFFF, 7);
    idle(0);

    tag = "R1";
    do_reset();
    for (int s = 0; s < 6; s++) idle(s);
    prot(0, 4, 0);

    done = 1;
    report();
    $finish;
  end

endmodule